// File: doc/BRIEF.md
# PPS-Gated Continuous Frequency Counter

This block measures an unknown signal against a once-per-second gate pulse from a satellite timing receiver. Two counters run without pause. One counts rising edges of the unknown signal, and the other counts cycles of the local system clock. On every accepted rising edge of the gate, the running values of both counters are frozen into one record. The record also holds the wrap count of each counter and a capture sequence number for each channel.

Neither counter is ever stopped or cleared between gates. Downstream logic therefore gets the edge frequency as the difference between two successive records. The difference between successive reference counts calibrates the local clock against the gate.

Both inputs pass through a two-stage synchroniser. The gate is also debounced: a new level must persist for a set number of clock samples before it counts. The unknown-signal counter is split into a low part that counts edges and a high part that advances when the low part rolls over. A capture always sees the full count, including a carry from the same cycle. Each record is held on a valid/ready output. If a new gate arrives before the previous record is taken, the new record replaces the old one and a sticky overrun flag is set.

Top module: `fc_pps_counter`

## Requirements
- R1: A synchronous active-high reset clears both counters, both wrap counts, both sequence numbers, the valid flag and the overrun flag. The first record after reset carries sequence number 1 on both channels.
- R2: A rising edge of `sig_in`, first sampled at clock edge k, is added to the edge count at clock edge k+2. The input must stay low and high for at least one clock each.
- R3: The edge count is SIG_W = LO_W+HI_W bits wide. The low LO_W bits count edges, and the upper HI_W bits advance by one when the low part rolls over from all ones. The reported value is the upper part shifted left by LO_W plus the low part.
- R4: The signal wrap count (OVF_W bits) advances by one each time the full SIG_W-bit edge count rolls over to zero. The record carries its value at capture time.
- R5: The reference count (REF_W bits) advances by one on every clock edge outside reset and rolls over modulo 2^REF_W. Its own OVF_W-bit wrap count advances on each rollover.
- R6: Only a low-to-high change of the accepted gate level makes a capture. A high-to-low change makes none.
- R7: The synchronised gate must hold a new level for FILT_LEN consecutive clock samples before that level is accepted. A high pulse that lasts fewer than FILT_LEN samples causes no capture. A gate high first sampled at edge k is accepted, and captured, at edge k+1+FILT_LEN.
- R8: Each capture increments the signal sequence number and the reference sequence number (SEQ_W bits each, modulo 2^SEQ_W). The record carries the incremented values.
- R9: `rec_valid` rises on the clock edge of a capture. It stays high, with every record field unchanged, until a clock edge where `rec_ready` is high. It then falls unless a new capture arrives on that same edge.
- R10: A capture while `rec_valid` is high and `rec_ready` is low replaces the record and sets `rec_overrun`. The flag stays set until reset.
- R11: A capture holds the counter values as they stand after that clock edge. An unknown-signal edge counted, or a low-part carry, on the capture edge itself is therefore included, so that successive edge counts never move backward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the reference being counted |
| rst | input | 1 | Synchronous active-high reset |
| sig_in | input | 1 | Unknown signal whose rising edges are counted |
| pps_in | input | 1 | One-pulse-per-second gate |
| rec_ready | input | 1 | Consumer accepts the held record |
| rec_valid | output | 1 | A record is held |
| rec_overrun | output | 1 | Sticky: a record was replaced before it was taken |
| rec_sig_count | output | LO_W+HI_W | Captured edge count |
| rec_sig_wraps | output | OVF_W | Captured edge-count wrap number |
| rec_sig_seq | output | SEQ_W | Signal channel sequence number |
| rec_ref_count | output | REF_W | Captured reference count |
| rec_ref_wraps | output | OVF_W | Captured reference wrap number |
| rec_ref_seq | output | SEQ_W | Reference channel sequence number |

## Verification
The bench builds the block with LO_W=4, HI_W=3, REF_W=10, OVF_W=3, SEQ_W=4 and FILT_LEN=4. With these widths the low-part carry, the full edge-count rollover and the signal wrap count all occur many times in one run. The reference count and its wrap count also roll over several times, and the sequence numbers cycle through zero. The gate is swept against single signal edges at every offset so that an edge lands on the capture cycle itself. Gate pulses one sample shorter than the filter length are also applied, next to one of exactly the filter length.

// File: rtl/fc_pkg.sv
package fc_pkg;
    // Handshake flags of the record register.
    typedef struct packed {
        logic valid;
        logic overrun;
    } fc_flags_t;
endpackage

// File: rtl/fc_sync_edge.sv
module fc_sync_edge #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    localparam int RUN_W = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(FILT_LEN - 1);

    typedef struct packed {
        logic             s1;
        logic             s2;
        logic             lvl;
        logic [RUN_W-1:0] run;
    } sync_st_t;

    sync_st_t st_q, st_d;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
        if (st_q.s2 == st_q.lvl) begin
            st_d.run = '0;
        end else if (st_q.run == RUN_LAST) begin
            st_d.lvl = st_q.s2;
            st_d.run = '0;
        end else begin
            st_d.run = st_q.run + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rise = st_d.lvl & ~st_q.lvl;

    // R7: an accepted level always equals the synchronised sample it was taken from
    p_accept_from_sample_r7: assert property (@(posedge clk) disable iff (rst)
        (st_q.lvl != $past(st_q.lvl)) |-> ($past(st_q.s2) == st_q.lvl));

    generate
        if (FILT_LEN >= 2) begin : g_filt_chk
            // R7: a level is never accepted from a single sample
            p_filter_two_r7: assert property (@(posedge clk) disable iff (rst)
                (st_q.lvl != $past(st_q.lvl)) |-> ($past(st_q.s2, 2) == st_q.lvl));
        end
    endgenerate
endmodule

// File: rtl/fc_event_counter.sv
module fc_event_counter #(
    parameter int LO_W  = 16,
    parameter int HI_W  = 16,
    parameter int OVF_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 inc,
    output logic [LO_W+HI_W-1:0] cnt_next,
    output logic [OVF_W-1:0]     wraps_next
);
    localparam int CNT_W = LO_W + HI_W;

    typedef struct packed {
        logic [HI_W-1:0]  hi;
        logic [LO_W-1:0]  lo;
        logic [OVF_W-1:0] wr;
    } cnt_st_t;

    cnt_st_t st_q, st_d;
    logic    lo_carry;
    logic    full_wrap;

    always_comb begin
        lo_carry  = inc & (&st_q.lo);
        full_wrap = lo_carry & (&st_q.hi);
        st_d      = st_q;
        st_d.lo   = st_q.lo + LO_W'(inc);
        st_d.hi   = st_q.hi + HI_W'(lo_carry);
        st_d.wr   = st_q.wr + OVF_W'(full_wrap);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cnt_next   = {st_d.hi, st_d.lo};
    assign wraps_next = st_d.wr;

    logic [CNT_W-1:0] cnt_q;
    assign cnt_q = {st_q.hi, st_q.lo};

    // R3: the combined count only ever steps by exactly one
    p_step_one_r3: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + 1'b1));
    // R4: the wrap count moves only when the combined count lands on zero
    p_wrap_at_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (st_q.wr != $past(st_q.wr)) |-> (cnt_q == '0));
endmodule

// File: rtl/fc_capture.sv
module fc_capture
    import fc_pkg::*;
#(
    parameter int SIG_W = 32,
    parameter int REF_W = 32,
    parameter int OVF_W = 16,
    parameter int SEQ_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap,
    input  logic [SIG_W-1:0] sig_cnt,
    input  logic [OVF_W-1:0] sig_wr,
    input  logic [REF_W-1:0] ref_cnt,
    input  logic [OVF_W-1:0] ref_wr,
    input  logic             ready,
    output logic             valid,
    output logic             overrun,
    output logic [SIG_W-1:0] sig_cnt_o,
    output logic [OVF_W-1:0] sig_wr_o,
    output logic [SEQ_W-1:0] sig_seq_o,
    output logic [REF_W-1:0] ref_cnt_o,
    output logic [OVF_W-1:0] ref_wr_o,
    output logic [SEQ_W-1:0] ref_seq_o
);
    typedef struct packed {
        fc_flags_t        fl;
        logic [SIG_W-1:0] sig_cnt;
        logic [OVF_W-1:0] sig_wr;
        logic [SEQ_W-1:0] sig_seq;
        logic [REF_W-1:0] ref_cnt;
        logic [OVF_W-1:0] ref_wr;
        logic [SEQ_W-1:0] ref_seq;
    } rec_st_t;

    rec_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (cap) begin
            if (st_q.fl.valid && !ready) st_d.fl.overrun = 1'b1;
            st_d.fl.valid = 1'b1;
            st_d.sig_cnt  = sig_cnt;
            st_d.sig_wr   = sig_wr;
            st_d.sig_seq  = st_q.sig_seq + 1'b1;
            st_d.ref_cnt  = ref_cnt;
            st_d.ref_wr   = ref_wr;
            st_d.ref_seq  = st_q.ref_seq + 1'b1;
        end else if (st_q.fl.valid && ready) begin
            st_d.fl.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign valid     = st_q.fl.valid;
    assign overrun   = st_q.fl.overrun;
    assign sig_cnt_o = st_q.sig_cnt;
    assign sig_wr_o  = st_q.sig_wr;
    assign sig_seq_o = st_q.sig_seq;
    assign ref_cnt_o = st_q.ref_cnt;
    assign ref_wr_o  = st_q.ref_wr;
    assign ref_seq_o = st_q.ref_seq;

    // R9: an untaken record stays put while no new capture arrives
    p_hold_record_r9: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready && !cap) |=> (valid && $stable(sig_cnt_o) && $stable(ref_cnt_o)
                                       && $stable(sig_seq_o)));
    // R10: overrun is sticky
    p_overrun_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);
    // R10: a replaced record raises overrun
    p_overrun_set_r10: assert property (@(posedge clk) disable iff (rst)
        (cap && valid && !ready) |=> overrun);
    // R8: each capture advances both sequence numbers by one
    p_seq_step_r8: assert property (@(posedge clk) disable iff (rst)
        cap |=> ((sig_seq_o == $past(sig_seq_o) + 1'b1) && (ref_seq_o == $past(ref_seq_o) + 1'b1)));
endmodule

// File: rtl/fc_pps_counter.sv
module fc_pps_counter #(
    parameter int LO_W     = 16,
    parameter int HI_W     = 16,
    parameter int REF_W    = 32,
    parameter int OVF_W    = 16,
    parameter int SEQ_W    = 32,
    parameter int FILT_LEN = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sig_in,
    input  logic                 pps_in,
    input  logic                 rec_ready,
    output logic                 rec_valid,
    output logic                 rec_overrun,
    output logic [LO_W+HI_W-1:0] rec_sig_count,
    output logic [OVF_W-1:0]     rec_sig_wraps,
    output logic [SEQ_W-1:0]     rec_sig_seq,
    output logic [REF_W-1:0]     rec_ref_count,
    output logic [OVF_W-1:0]     rec_ref_wraps,
    output logic [SEQ_W-1:0]     rec_ref_seq
);
    localparam int SIG_W    = LO_W + HI_W;
    localparam int REF_LO_W = REF_W / 2;
    localparam int REF_HI_W = REF_W - REF_LO_W;

    logic             sig_rise;
    logic             gate_rise;
    logic [SIG_W-1:0] sig_cnt_next;
    logic [OVF_W-1:0] sig_wr_next;
    logic [REF_W-1:0] ref_cnt_next;
    logic [OVF_W-1:0] ref_wr_next;

    fc_sync_edge #(.FILT_LEN(1)) u_sig_sync (
        .clk(clk), .rst(rst), .din(sig_in), .rise(sig_rise)
    );

    fc_sync_edge #(.FILT_LEN(FILT_LEN)) u_gate_sync (
        .clk(clk), .rst(rst), .din(pps_in), .rise(gate_rise)
    );

    fc_event_counter #(.LO_W(LO_W), .HI_W(HI_W), .OVF_W(OVF_W)) u_sig_cnt (
        .clk(clk), .rst(rst), .inc(sig_rise),
        .cnt_next(sig_cnt_next), .wraps_next(sig_wr_next)
    );

    fc_event_counter #(.LO_W(REF_LO_W), .HI_W(REF_HI_W), .OVF_W(OVF_W)) u_ref_cnt (
        .clk(clk), .rst(rst), .inc(1'b1),
        .cnt_next(ref_cnt_next), .wraps_next(ref_wr_next)
    );

    fc_capture #(.SIG_W(SIG_W), .REF_W(REF_W), .OVF_W(OVF_W), .SEQ_W(SEQ_W)) u_cap (
        .clk(clk), .rst(rst), .cap(gate_rise),
        .sig_cnt(sig_cnt_next), .sig_wr(sig_wr_next),
        .ref_cnt(ref_cnt_next), .ref_wr(ref_wr_next),
        .ready(rec_ready),
        .valid(rec_valid), .overrun(rec_overrun),
        .sig_cnt_o(rec_sig_count), .sig_wr_o(rec_sig_wraps), .sig_seq_o(rec_sig_seq),
        .ref_cnt_o(rec_ref_count), .ref_wr_o(rec_ref_wraps), .ref_seq_o(rec_ref_seq)
    );

    // R6: a record is only ever produced by a rising gate, never on its own
    p_valid_needs_gate_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(rec_valid) |-> $past(gate_rise));
    // R11: a capture with no edge that cycle holds the count already reached
    p_capture_current_r11: assert property (@(posedge clk) disable iff (rst)
        (gate_rise && !sig_rise) |=> (rec_sig_count == $past(sig_cnt_next)));
endmodule

// File: tb/tb_fc_pps_counter.sv
module tb_fc_pps_counter;
    localparam int CLK_PERIOD = 10;
    localparam int LO_W  = 4;
    localparam int HI_W  = 3;
    localparam int REF_W = 10;
    localparam int OVF_W = 3;
    localparam int SEQ_W = 4;
    localparam int FILT  = 4;
    localparam int SIG_W = LO_W + HI_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sig_in = 1'b0;
    logic pps_in = 1'b0;
    logic rec_ready = 1'b1;
    logic rec_valid, rec_overrun;
    logic [SIG_W-1:0] rec_sig_count;
    logic [OVF_W-1:0] rec_sig_wraps, rec_ref_wraps;
    logic [SEQ_W-1:0] rec_sig_seq, rec_ref_seq;
    logic [REF_W-1:0] rec_ref_count;

    fc_pps_counter #(.LO_W(LO_W), .HI_W(HI_W), .REF_W(REF_W), .OVF_W(OVF_W),
                     .SEQ_W(SEQ_W), .FILT_LEN(FILT)) dut (
        .clk(clk), .rst(rst), .sig_in(sig_in), .pps_in(pps_in), .rec_ready(rec_ready),
        .rec_valid(rec_valid), .rec_overrun(rec_overrun),
        .rec_sig_count(rec_sig_count), .rec_sig_wraps(rec_sig_wraps), .rec_sig_seq(rec_sig_seq),
        .rec_ref_count(rec_ref_count), .rec_ref_wraps(rec_ref_wraps), .rec_ref_seq(rec_ref_seq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int cyc    = 0;

    task automatic chk(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit     m_sd1, m_sd2, m_slvl;
    bit     m_gd1, m_gd2, m_glvl;
    int     m_run;
    longint m_edges, m_ticks, m_caps;
    bit     m_valid, m_ovr;
    longint e_sig, e_ref, e_caps;

    always @(posedge clk) begin
        bit sv, gv, cap;
        if (rst) begin
            m_sd1 = 0; m_sd2 = 0; m_slvl = 0;
            m_gd1 = 0; m_gd2 = 0; m_glvl = 0; m_run = 0;
            m_edges = 0; m_ticks = 0; m_caps = 0;
            m_valid = 0; m_ovr = 0;
            e_sig = 0; e_ref = 0; e_caps = 0;
        end else begin
            m_ticks++;
            sv = m_sd2; m_sd2 = m_sd1; m_sd1 = sig_in;
            if (sv && !m_slvl) m_edges++;
            m_slvl = sv;
            gv = m_gd2; m_gd2 = m_gd1; m_gd1 = pps_in;
            cap = 0;
            if (gv == m_glvl) m_run = 0;
            else if (m_run == FILT - 1) begin
                m_glvl = gv; m_run = 0; cap = gv;
            end else m_run++;
            if (cap) begin
                if (m_valid && !rec_ready) m_ovr = 1;
                m_valid = 1;
                m_caps++;
                e_sig = m_edges; e_ref = m_ticks; e_caps = m_caps;
            end else if (m_valid && rec_ready) m_valid = 0;
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (rst) begin
            chk("R1 valid in reset", rec_valid, 0);
            chk("R1 overrun in reset", rec_overrun, 0);
        end else begin
            chk("R9 valid", rec_valid, m_valid);
            chk("R10 overrun", rec_overrun, m_ovr);
            if (m_valid) begin
                chk("R2/R3/R11 sig count", rec_sig_count, e_sig % (64'd1 << SIG_W));
                chk("R4 sig wraps", rec_sig_wraps, (e_sig >> SIG_W) % (64'd1 << OVF_W));
                chk("R5 ref count", rec_ref_count, e_ref % (64'd1 << REF_W));
                chk("R5 ref wraps", rec_ref_wraps, (e_ref >> REF_W) % (64'd1 << OVF_W));
                chk("R8 sig seq", rec_sig_seq, e_caps % (64'd1 << SEQ_W));
                chk("R8 ref seq", rec_ref_seq, e_caps % (64'd1 << SEQ_W));
            end
        end
    end

    // unknown-signal generator
    int sig_mode  = 0;  // 0 toggle, 1 random, 2 forced
    bit sig_force = 0;
    always @(negedge clk) begin
        case (sig_mode)
            0: sig_in <= ~sig_in;
            1: sig_in <= 1'($urandom % 2);
            default: sig_in <= sig_force;
        endcase
    end

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic gate_pulse(int hi, int lo);
        pps_in = 1'b1; wait_n(hi);
        pps_in = 1'b0; wait_n(lo);
    endtask

    initial begin
        rst = 1'b1; rec_ready = 1'b0;
        wait_n(4);
        rst = 1'b0;
        wait_n(2);
        chk("R1 valid after reset", rec_valid, 0);

        // first record held: R1 seq and R9 hold
        gate_pulse(50, 20);
        chk("R1 first sig seq", rec_sig_seq, 1);
        chk("R1 first ref seq", rec_ref_seq, 1);
        chk("R9 held valid", rec_valid, 1);
        wait_n(30);
        chk("R9 still valid", rec_valid, 1);
        rec_ready = 1'b1;
        wait_n(2);
        chk("R9 taken", rec_valid, 0);

        // main function, toggle and random signal
        for (int i = 0; i < 24; i++) begin
            sig_mode = i % 2;
            gate_pulse(40 + i, 160 - i);
        end

        // R7 glitch filter
        rec_ready = 1'b0;
        sig_mode  = 0;
        for (int w = 1; w < FILT; w++) begin
            gate_pulse(w, 25);
            chk("R7 short pulse ignored", rec_valid, 0);
        end
        gate_pulse(FILT, 25);
        chk("R7 full length accepted", rec_valid, 1);
        rec_ready = 1'b1; wait_n(2); rec_ready = 1'b0;

        // R6 falling edge does not capture
        pps_in = 1'b1; wait_n(20);
        rec_ready = 1'b1; wait_n(2); rec_ready = 1'b0;
        pps_in = 1'b0; wait_n(30);
        chk("R6 falling gate ignored", rec_valid, 0);
        rec_ready = 1'b1;

        // R11 sweep: signal edge at each offset around the capture edge
        sig_mode = 2;
        for (int off = 0; off < 8; off++) begin
            sig_force = 1'b0; wait_n(20);
            pps_in = 1'b1; wait_n(off);
            sig_force = 1'b1; wait_n(30);
            sig_force = 1'b0; pps_in = 1'b0; wait_n(20);
        end

        // R10 overrun
        sig_mode = 1;
        chk("R10 no overrun yet", rec_overrun, 0);
        rec_ready = 1'b0;
        gate_pulse(30, 40);
        gate_pulse(30, 40);
        chk("R10 overrun set", rec_overrun, 1);
        chk("R10 record replaced seq", rec_sig_seq, e_caps % (64'd1 << SEQ_W));
        rec_ready = 1'b1;
        wait_n(5);
        chk("R10 overrun sticky", rec_overrun, 1);

        // long random run: wraps of every counter
        for (int i = 0; i < 30; i++) begin
            rec_ready = 1'($urandom % 2);
            gate_pulse(20 + (i % 7), 100 + (i % 13));
        end
        rec_ready = 1'b1;
        wait_n(10);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL R9 watchdog actual=%0d expected=completion", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule